// File: doc/BRIEF.md
# Low-Power Halt and Wake Sequencer

The sequencer moves a chip into its deepest stop state and brings it back. When the processor raises a halt request, the core clock keeps running for a drain interval so that the pipeline and any pending bus traffic can finish. The interval length is picked by a two-bit divider select. Once it ends, the core clock, the peripheral clocks and the PLL are switched off. The oscillator is switched off too, but only when the clock source is a crystal or resonator. With an external clock input it stays on.

Wake-up starts when the active-low wake pin goes low. The pin is asynchronous. It sets a latch at once, and a two-flop synchronizer brings that latch into the oscillator clock domain. The oscillator enable is raised first. The block then waits for the stable-oscillator input. After that it counts a fixed PLL lock interval, which is applied even when the PLL is bypassed. Finally it re-enables every clock and gives the interrupt logic a one-cycle wake pulse. For a short guard window right after the halt request, wake activity is discarded. A sticky error flag records a halt that drained while the external bus was still busy.

Top module: `halt_wake_seq`

## Requirements
- R1: After reset, stateCode is 0 (run), coreClkEn, periphClkEn, pllEn and oscEn are all 1, and wakeEvt and busErr are 0.
- R2: The clock edge that captures haltReq in run is edge E0. coreClkEn then stays 1 for exactly D more clock edges and is 0 after edge E0+D. D is DRAIN_BASE when divSel is 00 or 01, 2*DRAIN_BASE when divSel is 10, and 4*DRAIN_BASE when divSel is 11.
- R3: When the drain ends, stateCode becomes 2 (halted), and coreClkEn, periphClkEn and pllEn are all 0.
- R4: In the halted state, oscEn is 0 when xtalSel is 1 and 1 when xtalSel is 0.
- R5: While the sequencer is halted, wakeN going low moves it within 4 clock cycles to stateCode 3 (waiting for the oscillator) with oscEn at 1. A low level that is already present when the guard window ends also counts as a wake.
- R6: A low pulse on wakeN that starts and ends within the GUARD cycles after E0 never starts a wake. The sequencer stays halted.
- R7: In stateCode 3, the sequencer stays in that state for as long as oscStable is 0.
- R8: The clock edge that first sees oscStable at 1 in stateCode 3 is edge S. stateCode is then 4 (PLL lock), pllEn is 1 and coreClkEn is 0 until edge S+LOCK_CYCLES. With default parameters LOCK_CYCLES is 131072.
- R9: After edge S+LOCK_CYCLES, all four enables are 1, stateCode is 5 and wakeEvt is 1 for exactly one cycle. After the next edge, stateCode is 0 and wakeEvt is 0.
- R10: A haltReq seen in any state other than run is ignored. The drain length does not change, and a halted sequencer stays halted.
- R11: busErr is set if busBusy is 1 on the last drain cycle. Once set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock |
| rstN | input | 1 | Active-low asynchronous reset |
| haltReq | input | 1 | Halt request from the processor |
| divSel | input | 2 | Divider select that picks the drain length |
| xtalSel | input | 1 | 1 when the clock source is a crystal or resonator |
| busBusy | input | 1 | External bus access in progress |
| wakeN | input | 1 | Asynchronous active-low wake pin |
| oscStable | input | 1 | Oscillator reports a stable output |
| coreClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| pllEn | output | 1 | PLL enable |
| oscEn | output | 1 | Oscillator enable |
| wakeEvt | output | 1 | One-cycle wake pulse to the interrupt logic |
| busErr | output | 1 | Sticky flag: halted with the bus still busy |
| stateCode | output | 3 | Current state: 0 run, 1 drain, 2 halted, 3 oscillator wait, 4 PLL lock, 5 resume |

## Verification
The hardest case to reach is the guard window. A wake edge there has to start and end within the first few cycles after the halt request is captured, while the latch that catches it is asynchronous. The stimulus drops wakeN on the falling clock edge right after the capture edge and raises it one cycle later. It then runs through the whole drain and confirms that the sequencer stays halted. A second run holds the pin low through the window, so that the level-sensitive wake can be seen taking over once the guard ends.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_DRAIN    = 3'd1,
    ST_HALTED   = 3'd2,
    ST_OSC_WAIT = 3'd3,
    ST_PLL_LOCK = 3'd4,
    ST_RESUME   = 3'd5
  } hwsState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadDrain;
    logic loadLock;
    logic decr;
    logic wakeClr;
    logic checkBusy;
  } hwsStrobe_t;

endpackage

// File: rtl/hws_datapath.sv
module hws_datapath
  import hws_pkg::*;
#(
  parameter int DRAIN_BASE  = 16,
  parameter int LOCK_CYCLES = 131072,
  parameter int GUARD       = 4,
  parameter int CNT_W       = 18,
  parameter int GUARD_W     = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  hwsStrobe_t strobe,
  input  logic [1:0] divSel,
  input  logic       busBusy,
  input  logic       wakeN,
  output logic       cntZero,
  output logic       wakeSeen,
  output logic       busErr
);

  localparam logic [CNT_W-1:0]   DRAIN_X1   = CNT_W'(DRAIN_BASE - 1);
  localparam logic [CNT_W-1:0]   DRAIN_X2   = CNT_W'(2 * DRAIN_BASE - 1);
  localparam logic [CNT_W-1:0]   DRAIN_X4   = CNT_W'(4 * DRAIN_BASE - 1);
  localparam logic [CNT_W-1:0]   LOCK_LOAD  = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [GUARD_W-1:0] GUARD_LOAD = GUARD_W'(GUARD);

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   drainLoad;
  logic [GUARD_W-1:0] guardCnt;
  logic               guardActive;
  logic               wakeLatch;
  logic               wakeMeta;
  logic               wakeSync;
  logic               latchClr;

  // Drain length chosen by the divider select
  always_comb begin
    case (divSel)
      2'b10:   drainLoad = DRAIN_X2;
      2'b11:   drainLoad = DRAIN_X4;
      default: drainLoad = DRAIN_X1;
    endcase
  end

  // Shared down-counter for drain and lock intervals
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cnt <= '0;
    else if (strobe.loadDrain)          cnt <= drainLoad;
    else if (strobe.loadLock)           cnt <= LOCK_LOAD;
    else if (strobe.decr && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // Guard window after halt capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  guardCnt <= '0;
    else if (strobe.loadDrain)  guardCnt <= GUARD_LOAD;
    else if (guardCnt != '0)    guardCnt <= guardCnt - 1'b1;
  end

  assign guardActive = (guardCnt != '0);
  assign latchClr    = strobe.wakeClr | guardActive;

  // Asynchronous-set wake latch; pin low dominates the clear
  always_ff @(posedge clk or negedge wakeN or negedge rstN) begin
    if (!rstN)         wakeLatch <= 1'b0;
    else if (!wakeN)   wakeLatch <= 1'b1;
    else if (latchClr) wakeLatch <= 1'b0;
  end

  // Two-flop synchronizer into the oscillator domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeMeta <= 1'b0;
      wakeSync <= 1'b0;
    end else begin
      wakeMeta <= wakeLatch;
      wakeSync <= wakeMeta;
    end
  end

  assign wakeSeen = wakeSync;

  // Sticky bus error
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            busErr <= 1'b0;
    else if (strobe.checkBusy && busBusy) busErr <= 1'b1;
  end

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> busErr);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decr && !cntZero && !strobe.loadDrain && !strobe.loadLock)
      |=> cnt == $past(cnt) - 1'b1);

  // R6
  guard_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDrain |=> guardCnt == GUARD_LOAD);

endmodule

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic       xtalSel,
  input  logic       oscStable,
  input  logic       cntZero,
  input  logic       wakeSeen,
  output hwsStrobe_t strobe,
  output logic       coreClkEn,
  output logic       periphClkEn,
  output logic       pllEn,
  output logic       oscEn,
  output logic       wakeEvt,
  output hwsState_e  state
);

  hwsState_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:      if (haltReq)   stateNext = ST_DRAIN;
      ST_DRAIN:    if (cntZero)   stateNext = ST_HALTED;
      ST_HALTED:   if (wakeSeen)  stateNext = ST_OSC_WAIT;
      ST_OSC_WAIT: if (oscStable) stateNext = ST_PLL_LOCK;
      ST_PLL_LOCK: if (cntZero)   stateNext = ST_RESUME;
      ST_RESUME:                  stateNext = ST_RUN;
      default:                    stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.loadDrain = (state == ST_RUN) && haltReq;
    strobe.loadLock  = (state == ST_OSC_WAIT) && oscStable;
    strobe.decr      = (state == ST_DRAIN) || (state == ST_PLL_LOCK);
    strobe.wakeClr   = (state == ST_RUN) || (state == ST_RESUME);
    strobe.checkBusy = (state == ST_DRAIN) && cntZero;
  end

  always_comb begin
    coreClkEn   = 1'b1;
    periphClkEn = 1'b1;
    pllEn       = 1'b1;
    oscEn       = 1'b1;
    wakeEvt     = 1'b0;
    case (state)
      ST_HALTED: begin
        coreClkEn   = 1'b0;
        periphClkEn = 1'b0;
        pllEn       = 1'b0;
        oscEn       = !xtalSel;
      end
      ST_OSC_WAIT: begin
        coreClkEn   = 1'b0;
        periphClkEn = 1'b0;
        pllEn       = 1'b0;
      end
      ST_PLL_LOCK: begin
        coreClkEn   = 1'b0;
        periphClkEn = 1'b0;
      end
      ST_RESUME: wakeEvt = 1'b1;
      default: ;
    endcase
  end

  // R3
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALTED && $past(state) == ST_DRAIN) |-> $past(cntZero));

  // R8
  lock_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PLL_LOCK && cntZero) |=> state == ST_RESUME);

  // R9
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |=> !wakeEvt);

  // R9
  resume_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESUME) |-> $past(state) == ST_PLL_LOCK);

  // R7
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OSC_WAIT && !oscStable) |=> state == ST_OSC_WAIT);

endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import hws_pkg::*;
#(
  parameter int DRAIN_BASE  = 16,
  parameter int LOCK_CYCLES = 131072,
  parameter int GUARD       = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic [1:0] divSel,
  input  logic       xtalSel,
  input  logic       busBusy,
  input  logic       wakeN,
  input  logic       oscStable,
  output logic       coreClkEn,
  output logic       periphClkEn,
  output logic       pllEn,
  output logic       oscEn,
  output logic       wakeEvt,
  output logic       busErr,
  output logic [2:0] stateCode
);

  localparam int LOCK_W  = $clog2(LOCK_CYCLES) + 1;
  localparam int DRAIN_W = $clog2(4 * DRAIN_BASE) + 1;
  localparam int CNT_W   = (LOCK_W > DRAIN_W) ? LOCK_W : DRAIN_W;
  localparam int GUARD_W = $clog2(GUARD + 1);

  hwsStrobe_t strobe;
  hwsState_e  state;
  logic       cntZero;
  logic       wakeSeen;

  hws_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .haltReq    (haltReq),
    .xtalSel    (xtalSel),
    .oscStable  (oscStable),
    .cntZero    (cntZero),
    .wakeSeen   (wakeSeen),
    .strobe     (strobe),
    .coreClkEn  (coreClkEn),
    .periphClkEn(periphClkEn),
    .pllEn      (pllEn),
    .oscEn      (oscEn),
    .wakeEvt    (wakeEvt),
    .state      (state)
  );

  hws_datapath #(
    .DRAIN_BASE (DRAIN_BASE),
    .LOCK_CYCLES(LOCK_CYCLES),
    .GUARD      (GUARD),
    .CNT_W      (CNT_W),
    .GUARD_W    (GUARD_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .divSel  (divSel),
    .busBusy (busBusy),
    .wakeN   (wakeN),
    .cntZero (cntZero),
    .wakeSeen(wakeSeen),
    .busErr  (busErr)
  );

  assign stateCode = state;

endmodule

// File: tb/halt_wake_seq_tb.sv
module halt_wake_seq_tb;

  localparam int BASE = 16;
  localparam int LOCK = 200;
  localparam int GRD  = 4;

  localparam int S_RUN = 0, S_HALT = 2, S_OSCW = 3, S_LOCK = 4, S_RES = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 1'b0;
  logic [1:0] divSel = 2'b00;
  logic xtalSel = 1'b0;
  logic busBusy = 1'b0;
  logic wakeN = 1'b1;
  logic oscStable = 1'b1;
  logic coreClkEn, periphClkEn, pllEn, oscEn, wakeEvt, busErr;
  logic [2:0] stateCode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  halt_wake_seq #(.DRAIN_BASE(BASE), .LOCK_CYCLES(LOCK), .GUARD(GRD)) u_dut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .divSel(divSel),
    .xtalSel(xtalSel), .busBusy(busBusy), .wakeN(wakeN),
    .oscStable(oscStable), .coreClkEn(coreClkEn), .periphClkEn(periphClkEn),
    .pllEn(pllEn), .oscEn(oscEn), .wakeEvt(wakeEvt), .busErr(busErr),
    .stateCode(stateCode)
  );

  typedef struct packed {
    logic [1:0] div;
    logic       xtal;
    logic       busy;
    logic [7:0] len;
    logic       err;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'b00, 1'b1, 1'b0, 8'd16, 1'b0},
    '{2'b01, 1'b0, 1'b0, 8'd16, 1'b0},
    '{2'b10, 1'b1, 1'b1, 8'd32, 1'b1},
    '{2'b11, 1'b0, 1'b0, 8'd64, 1'b0},
    '{2'b11, 1'b1, 1'b1, 8'd64, 1'b1},
    '{2'b10, 1'b0, 1'b0, 8'd32, 1'b0}
  };

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    haltReq = 1'b0; wakeN = 1'b1; oscStable = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Pulse halt; returns edges after E0 until coreClkEn falls
  task automatic haltAndMeasure(output int n, input int holdHigh);
    haltReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (holdHigh == 0) haltReq = 1'b0;
    n = 0;
    while (coreClkEn && n < 200) begin
      @(posedge clk);
      n++;
      if (n == holdHigh) haltReq = 1'b0;
      @(negedge clk);
    end
    haltReq = 1'b0;
  endtask

  // Wake from halted and check lock length and resume
  task automatic wakeAndCheck(input logic xtal);
    int n;
    int w;
    if (xtal) oscStable = 1'b0;
    wakeN = 1'b0;
    @(negedge clk);
    wakeN = 1'b1;
    w = 1;
    while (stateCode != S_OSCW && w < 10) begin @(negedge clk); w++; end
    chk(stateCode == S_OSCW && w <= 4, "R5 wake to osc wait", w, 4);
    chk(oscEn == 1'b1, "R5 oscEn on wake", oscEn, 1);
    if (xtal) begin
      repeat (20) @(negedge clk);
      chk(stateCode == S_OSCW, "R7 hold without stable", stateCode, S_OSCW);
      oscStable = 1'b1;
    end
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) chk(stateCode == S_LOCK && pllEn && !coreClkEn,
                      "R8 lock state", stateCode, S_LOCK);
    end while (!coreClkEn && n < LOCK + 20);
    chk(n == LOCK + 1, "R8 lock length", n, LOCK + 1);
    chk(wakeEvt && periphClkEn && pllEn && oscEn && stateCode == S_RES,
        "R9 resume", stateCode, S_RES);
    @(negedge clk);
    chk(!wakeEvt && stateCode == S_RUN, "R9 pulse ends", wakeEvt, 0);
  endtask

  initial begin
    int n;
    doReset();
    // R1
    chk(stateCode == S_RUN, "R1 state", stateCode, S_RUN);
    chk(coreClkEn && periphClkEn && pllEn && oscEn, "R1 enables",
        {coreClkEn, periphClkEn, pllEn, oscEn}, 15);
    chk(!wakeEvt && !busErr, "R1 flags", {wakeEvt, busErr}, 0);

    foreach (VEC[i]) begin
      doReset();
      divSel = VEC[i].div; xtalSel = VEC[i].xtal; busBusy = VEC[i].busy;
      haltAndMeasure(n, 0);
      chk(n == int'(VEC[i].len), "R2 drain length", n, int'(VEC[i].len));
      chk(stateCode == S_HALT && !periphClkEn && !pllEn, "R3 halted",
          stateCode, S_HALT);
      chk(oscEn == !VEC[i].xtal, "R4 oscEn in halt", oscEn, !VEC[i].xtal);
      chk(busErr == VEC[i].err, "R11 bus error", busErr, VEC[i].err);
      busBusy = 1'b0;
      wakeAndCheck(VEC[i].xtal);
      chk(busErr == VEC[i].err, "R11 sticky", busErr, VEC[i].err);
    end

    // R6: guard-window pulse ignored
    doReset();
    divSel = 2'b00; xtalSel = 1'b1;
    haltReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    haltReq = 1'b0;
    wakeN = 1'b0;
    @(negedge clk);
    wakeN = 1'b1;
    repeat (BASE + 12) @(negedge clk);
    chk(stateCode == S_HALT, "R6 guard pulse ignored", stateCode, S_HALT);
    // R10: halt request while halted
    haltReq = 1'b1;
    repeat (3) @(negedge clk);
    haltReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(stateCode == S_HALT && !coreClkEn, "R10 halt in halted", stateCode, S_HALT);
    wakeAndCheck(1'b1);

    // R10: halt held high during drain does not stretch it
    doReset();
    divSel = 2'b10; xtalSel = 1'b0;
    haltAndMeasure(n, 6);
    chk(n == 2 * BASE, "R10 drain unchanged", n, 2 * BASE);
    wakeAndCheck(1'b0);

    // R5: low level held through the guard window wakes after drain
    doReset();
    divSel = 2'b00; xtalSel = 1'b0;
    haltReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    haltReq = 1'b0;
    wakeN = 1'b0;
    n = 0;
    while (stateCode != S_OSCW && n < BASE + 20) begin @(negedge clk); n++; end
    chk(stateCode == S_OSCW && n <= BASE + 1, "R5 held level wakes", n, BASE);
    wakeN = 1'b1;

    finishRun();
  end

endmodule